// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block sequences the low-power states of a small microcontroller core. When the core retires a sleep instruction, it raises a one-cycle request. The block then reads a 3-bit mode code and a sleep-enable bit. If the request is legal, it gates the clocks of each domain (CPU, program memory, peripheral I/O, ADC, asynchronous timer) and can stop the main oscillator. While asleep, it watches a vector of wake sources. Only the sources that the chosen mode allows can end the sleep.

A protected brown-out-sleep bit lets software turn the supply monitor off for the deepest mode. The bit can change only through an unlock-then-write sequence. When the monitor was off during sleep, wake-up turns the monitor back on at once. The CPU clock then stays held for a fixed settle count, so the monitor is valid before code runs again. On entry to the lighter modes, the block can also start an ADC conversion.

Top module: `sleep_power_ctrl`

## Requirements
- R1: After reset, every clock enable, `osc_run` and `bod_en` are 1, while `bod_sleep` and `adc_start` are 0.
- R2: Mode 000 (light sleep) clears `clk_en_cpu` and `clk_en_flash` in the cycle after the accepted request. `clk_en_io`, `clk_en_adc`, `clk_en_async` and `osc_run` stay 1.
- R3: Mode 001 (quiet conversion) clears `clk_en_cpu`, `clk_en_flash` and `clk_en_io`. `clk_en_adc`, `clk_en_async` and `osc_run` stay 1.
- R4: Mode 010 (deep sleep) clears all five clock enables and `osc_run`.
- R5: A request with `sleep_en`=0, or with a mode code of 011 to 111, changes no output. The CPU clock keeps running.
- R6: Wake bits are: 0 ADC done, 1 reset request, 2 watchdog, 3 address match, 4 async timer, 5 memory ready, 6 external level, 7 pin change, 8 timer overflow, 9 transmit done. Mode 000 accepts all of them. Mode 001 accepts bits 0 to 7. Mode 010 accepts bits 1, 2, 3, 6 and 7. A bit that the mode does not accept leaves the block asleep.
- R7: When the monitor stayed on, an accepted wake bit brings `clk_en_cpu` back in the next cycle.
- R8: Entry to mode 000 or 001 with `adc_on`=1 raises `adc_start` for exactly one cycle, in the first sleep cycle. Entry to mode 010, or entry with `adc_on`=0, raises no pulse.
- R9: `bod_en` falls in the first sleep cycle only when `bod_sleep`=1 and the mode is 010. In every other mode it stays 1.
- R10: When `bod_en` was 0, wake-up sets `bod_en` to 1 in the next cycle. `clk_en_cpu` then stays 0 for exactly SETTLE_CYC cycles, counted from that cycle.
- R11: A write with `cfg_unlock`=1 and `cfg_bods`=1 does not change `bod_sleep`. Instead it opens a window of UNLOCK_WIN (4) cycles. A write with `cfg_unlock`=0 inside the window loads `cfg_bods` into `bod_sleep` and closes the window. Such a write outside the window is ignored.
- R12: When a sleep request and a `bod_sleep` update land in the same cycle, the sleep decision uses the value of `bod_sleep` from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Requested sleep mode code |
| sleep_en | input | 1 | Sleep permitted |
| sleep_pulse | input | 1 | One-cycle sleep request |
| adc_on | input | 1 | ADC is enabled |
| cfg_wr | input | 1 | Control write strobe |
| cfg_unlock | input | 1 | Unlock key bit of the write |
| cfg_bods | input | 1 | Brown-out-sleep value of the write |
| wake_src | input | 10 | Wake source vector (R6 map) |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_flash | output | 1 | Program memory clock enable |
| clk_en_io | output | 1 | Peripheral I/O clock enable |
| clk_en_adc | output | 1 | ADC clock enable |
| clk_en_async | output | 1 | Asynchronous timer clock enable |
| osc_run | output | 1 | Main oscillator run |
| bod_en | output | 1 | Brown-out monitor enable |
| adc_start | output | 1 | One-cycle conversion start |
| bod_sleep | output | 1 | Current brown-out-sleep bit |

## Verification
Two functions can meet in one cycle: the guarded write to the brown-out-sleep bit and the sleep request that reads that bit. The bench opens the unlock window. It then drives the loading write and a deep-sleep request on the same edge, with the bit at 0 before that edge. It judges the result at the ports: `bod_sleep` must read 1, `bod_en` must stay 1 through the sleep, and wake-up must return the CPU clock in the next cycle, with no settle delay.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int WAKE_W = 10;

    localparam int WK_ADC_DONE = 0;
    localparam int WK_RESET    = 1;
    localparam int WK_WDOG     = 2;
    localparam int WK_ADDR     = 3;
    localparam int WK_ATMR     = 4;
    localparam int WK_MEMRDY   = 5;
    localparam int WK_EXTLVL   = 6;
    localparam int WK_PINCHG   = 7;
    localparam int WK_TMROVF   = 8;
    localparam int WK_TXDONE   = 9;

    localparam logic [2:0] MODE_LIGHT = 3'b000;
    localparam logic [2:0] MODE_QUIET = 3'b001;
    localparam logic [2:0] MODE_DEEP  = 3'b010;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_SETTLE = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic cpu;
        logic flash;
        logic io;
        logic adc;
        logic tmr_async;
        logic osc;
    } clk_gate_t;

    function automatic logic mode_is_valid(input logic [2:0] m);
        return (m == MODE_LIGHT) || (m == MODE_QUIET) || (m == MODE_DEEP);
    endfunction

    function automatic logic [WAKE_W-1:0] wake_allow(input logic [2:0] m);
        logic [WAKE_W-1:0] a;
        a = '0;
        case (m)
            MODE_LIGHT: a = '1;
            MODE_QUIET: begin
                a[WK_ADC_DONE] = 1'b1;
                a[WK_RESET]    = 1'b1;
                a[WK_WDOG]     = 1'b1;
                a[WK_ADDR]     = 1'b1;
                a[WK_ATMR]     = 1'b1;
                a[WK_MEMRDY]   = 1'b1;
                a[WK_EXTLVL]   = 1'b1;
                a[WK_PINCHG]   = 1'b1;
            end
            MODE_DEEP: begin
                a[WK_RESET]    = 1'b1;
                a[WK_WDOG]     = 1'b1;
                a[WK_ADDR]     = 1'b1;
                a[WK_EXTLVL]   = 1'b1;
                a[WK_PINCHG]   = 1'b1;
            end
            default: a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/spc_bod_guard.sv
module spc_bod_guard #(
    parameter int UNLOCK_WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_unlock,
    input  logic cfg_bods,
    output logic bod_sleep
);
    localparam int WW = $clog2(UNLOCK_WIN + 1);

    typedef struct packed {
        logic [WW-1:0] win;
        logic          bods;
    } guard_t;

    guard_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (cfg_wr && cfg_unlock && cfg_bods) begin
            g_d.win = WW'(UNLOCK_WIN);
        end else if (cfg_wr && !cfg_unlock && (g_q.win != '0)) begin
            g_d.bods = cfg_bods;
            g_d.win  = '0;
        end else if (g_q.win != '0) begin
            g_d.win = g_q.win - WW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign bod_sleep = g_q.bods;

    AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.win == '0 && cfg_wr && !cfg_unlock) |=> $stable(bod_sleep)); // R11
    AST_OPEN_KEEPS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_unlock) |=> $stable(bod_sleep)); // R11

endmodule

// File: rtl/spc_wake_qual.sv
module spc_wake_qual
    import spc_pkg::*;
(
    input  logic [2:0]        mode,
    input  logic [WAKE_W-1:0] wake_src,
    output logic              wake_hit
);
    logic [WAKE_W-1:0] allow;
    logic [WAKE_W-1:0] hit_vec;

    assign allow = wake_allow(mode);

    for (genvar i = 0; i < WAKE_W; i++) begin : g_bit
        assign hit_vec[i] = wake_src[i] & allow[i];
    end

    assign wake_hit = |hit_vec;

endmodule

// File: rtl/spc_clk_decode.sv
module spc_clk_decode
    import spc_pkg::*;
(
    input  seq_state_t state,
    input  logic [2:0] mode,
    output clk_gate_t  gate
);
    always_comb begin
        gate = '{cpu: 1'b1, flash: 1'b1, io: 1'b1, adc: 1'b1, tmr_async: 1'b1, osc: 1'b1};
        case (state)
            ST_SLEEP: begin
                gate.cpu   = 1'b0;
                gate.flash = 1'b0;
                case (mode)
                    MODE_QUIET: gate.io = 1'b0;
                    MODE_DEEP: begin
                        gate.io        = 1'b0;
                        gate.adc       = 1'b0;
                        gate.tmr_async = 1'b0;
                        gate.osc       = 1'b0;
                    end
                    default: ;
                endcase
            end
            ST_SETTLE: begin
                gate.cpu   = 1'b0;
                gate.flash = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/spc_seq.sv
module spc_seq
    import spc_pkg::*;
#(
    parameter int SETTLE_CYC = 15000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_sel,
    input  logic       sleep_en,
    input  logic       sleep_pulse,
    input  logic       adc_on,
    input  logic       bod_sleep,
    input  logic       wake_hit,
    output seq_state_t state,
    output logic [2:0] mode,
    output logic       bod_off,
    output logic       adc_go
);
    localparam int CW = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        seq_state_t    st;
        logic [2:0]    mode;
        logic          bod_off;
        logic          adc_go;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.adc_go = 1'b0;
        case (s_q.st)
            ST_RUN: begin
                if (sleep_pulse && sleep_en && mode_is_valid(mode_sel)) begin
                    s_d.st      = ST_SLEEP;
                    s_d.mode    = mode_sel;
                    s_d.bod_off = bod_sleep && (mode_sel == MODE_DEEP);
                    s_d.adc_go  = adc_on && (mode_sel != MODE_DEEP);
                end
            end
            ST_SLEEP: begin
                if (wake_hit) begin
                    s_d.bod_off = 1'b0;
                    if (s_q.bod_off) begin
                        s_d.st  = ST_SETTLE;
                        s_d.cnt = CW'(SETTLE_CYC - 1);
                    end else begin
                        s_d.st = ST_RUN;
                    end
                end
            end
            ST_SETTLE: begin
                if (s_q.cnt == '0) s_d.st  = ST_RUN;
                else               s_d.cnt = s_q.cnt - CW'(1);
            end
            default: s_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_RUN, mode: MODE_LIGHT, bod_off: 1'b0, adc_go: 1'b0, cnt: '0};
        else        s_q <= s_d;
    end

    assign state   = s_q.st;
    assign mode    = s_q.mode;
    assign bod_off = s_q.bod_off;
    assign adc_go  = s_q.adc_go;

    AST_ILLEGAL_REQUEST_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_RUN && sleep_pulse && (!sleep_en || !mode_is_valid(mode_sel)))
        |=> (s_q.st == ST_RUN)); // R5
    AST_FAST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_SLEEP && wake_hit && !s_q.bod_off) |=> (s_q.st == ST_RUN)); // R7
    AST_SLOW_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_SLEEP && wake_hit && s_q.bod_off) |=> (s_q.st == ST_SETTLE)); // R10
    AST_BOD_BACK_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_SLEEP && wake_hit) |=> !s_q.bod_off); // R10
    AST_ADC_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.adc_go |=> !s_q.adc_go); // R8
    AST_BOD_OFF_DEEP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.bod_off |-> (s_q.mode == MODE_DEEP)); // R9

endmodule

// File: rtl/sleep_power_ctrl.sv
module sleep_power_ctrl
    import spc_pkg::*;
#(
    parameter int SETTLE_CYC = 15000,
    parameter int UNLOCK_WIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_sel,
    input  logic              sleep_en,
    input  logic              sleep_pulse,
    input  logic              adc_on,
    input  logic              cfg_wr,
    input  logic              cfg_unlock,
    input  logic              cfg_bods,
    input  logic [WAKE_W-1:0] wake_src,
    output logic              clk_en_cpu,
    output logic              clk_en_flash,
    output logic              clk_en_io,
    output logic              clk_en_adc,
    output logic              clk_en_async,
    output logic              osc_run,
    output logic              bod_en,
    output logic              adc_start,
    output logic              bod_sleep
);
    seq_state_t state;
    logic [2:0] mode;
    logic       bod_off;
    logic       adc_go;
    logic       wake_hit;
    logic       bods_bit;
    clk_gate_t  gate;

    spc_bod_guard #(.UNLOCK_WIN(UNLOCK_WIN)) u_guard (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_unlock(cfg_unlock),
        .cfg_bods(cfg_bods), .bod_sleep(bods_bit)
    );

    spc_wake_qual u_wake (
        .mode(mode), .wake_src(wake_src), .wake_hit(wake_hit)
    );

    spc_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sleep_en(sleep_en),
        .sleep_pulse(sleep_pulse), .adc_on(adc_on), .bod_sleep(bods_bit),
        .wake_hit(wake_hit), .state(state), .mode(mode), .bod_off(bod_off),
        .adc_go(adc_go)
    );

    spc_clk_decode u_dec (
        .state(state), .mode(mode), .gate(gate)
    );

    assign clk_en_cpu   = gate.cpu;
    assign clk_en_flash = gate.flash;
    assign clk_en_io    = gate.io;
    assign clk_en_adc   = gate.adc;
    assign clk_en_async = gate.tmr_async;
    assign osc_run      = gate.osc;
    assign bod_en       = !bod_off;
    assign adc_start    = adc_go;
    assign bod_sleep    = bods_bit;

    AST_OSC_NEEDS_CPU_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run |-> !clk_en_cpu); // R4
    AST_BOD_ON_WHILE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_cpu |-> bod_en); // R10

endmodule

// File: tb/sleep_power_ctrl_test.sv
module sleep_power_ctrl_test;
    localparam int SETTLE = 15000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic sleep_en = 1'b0, sleep_pulse = 1'b0, adc_on = 1'b0;
    logic cfg_wr = 1'b0, cfg_unlock = 1'b0, cfg_bods = 1'b0;
    logic [9:0] wake_src = '0;
    logic clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_async;
    logic osc_run, bod_en, adc_start, bod_sleep;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sleep_power_ctrl #(.SETTLE_CYC(SETTLE), .UNLOCK_WIN(4)) uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sleep_en(sleep_en),
        .sleep_pulse(sleep_pulse), .adc_on(adc_on), .cfg_wr(cfg_wr),
        .cfg_unlock(cfg_unlock), .cfg_bods(cfg_bods), .wake_src(wake_src),
        .clk_en_cpu(clk_en_cpu), .clk_en_flash(clk_en_flash), .clk_en_io(clk_en_io),
        .clk_en_adc(clk_en_adc), .clk_en_async(clk_en_async), .osc_run(osc_run),
        .bod_en(bod_en), .adc_start(adc_start), .bod_sleep(bod_sleep)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // gates packed as {cpu,flash,io,adc,async,osc}
    function automatic logic [5:0] gates();
        return {clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_async, osc_run};
    endfunction

    // All tasks start and end on a falling edge.
    task automatic request_sleep(input logic [2:0] m, input logic en);
        mode_sel = m; sleep_en = en; sleep_pulse = 1'b1;
        @(negedge clk);
        sleep_pulse = 1'b0;
    endtask

    task automatic wake_bit(input int idx);
        wake_src = 10'(1) << idx;
        @(negedge clk);
        wake_src = '0;
    endtask

    task automatic cfg_write(input logic unl, input logic val);
        cfg_wr = 1'b1; cfg_unlock = unl; cfg_bods = val;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_unlock = 1'b0; cfg_bods = 1'b0;
    endtask

    task automatic set_bods(input logic val);
        cfg_write(1'b1, 1'b1);
        cfg_write(1'b0, val);
        chk("R11 guarded load", bod_sleep, val);
    endtask

    task automatic t_reset();
        chk("R1 reset gates", gates(), 6'b111111);
        chk("R1 reset bod_en", bod_en, 1'b1);
        chk("R1 reset bod_sleep", bod_sleep, 1'b0);
        chk("R1 reset adc_start", adc_start, 1'b0);
    endtask

    task automatic t_light();
        adc_on = 1'b1;
        request_sleep(3'b000, 1'b1);
        chk("R2 light gates", gates(), 6'b001111);
        chk("R8 adc pulse light", adc_start, 1'b1);
        @(negedge clk);
        chk("R8 adc pulse single", adc_start, 1'b0);
        wake_bit(8);
        chk("R6 light timer overflow wakes / R7", clk_en_cpu, 1'b1);
        adc_on = 1'b0;
        request_sleep(3'b000, 1'b1);
        chk("R8 no pulse adc_on=0", adc_start, 1'b0);
        wake_bit(9);
        chk("R6 light tx done wakes", clk_en_cpu, 1'b1);
    endtask

    task automatic t_quiet();
        adc_on = 1'b1;
        request_sleep(3'b001, 1'b1);
        chk("R3 quiet gates", gates(), 6'b000111);
        chk("R8 adc pulse quiet", adc_start, 1'b1);
        wake_bit(8);
        chk("R6 quiet ignores timer overflow", clk_en_cpu, 1'b0);
        wake_bit(9);
        chk("R6 quiet ignores tx done", clk_en_cpu, 1'b0);
        wake_bit(0);
        chk("R6 quiet adc done wakes / R7", clk_en_cpu, 1'b1);
        adc_on = 1'b0;
    endtask

    task automatic t_deep();
        adc_on = 1'b1;
        request_sleep(3'b010, 1'b1);
        chk("R4 deep gates", gates(), 6'b000000);
        chk("R8 no pulse deep", adc_start, 1'b0);
        chk("R9 bod stays on (bit 0)", bod_en, 1'b1);
        wake_bit(0); chk("R6 deep ignores adc done", clk_en_cpu, 1'b0);
        wake_bit(4); chk("R6 deep ignores async timer", clk_en_cpu, 1'b0);
        wake_bit(5); chk("R6 deep ignores mem ready", clk_en_cpu, 1'b0);
        wake_bit(8); chk("R6 deep ignores timer overflow", clk_en_cpu, 1'b0);
        wake_bit(3);
        chk("R6 deep address match wakes / R7", gates(), 6'b111111);
        adc_on = 1'b0;
    endtask

    task automatic t_noop();
        request_sleep(3'b000, 1'b0);
        chk("R5 sleep_en=0 no-op", gates(), 6'b111111);
        for (int m = 3; m < 8; m++) begin
            request_sleep(3'(m), 1'b1);
            chk($sformatf("R5 reserved mode %0d no-op", m), gates(), 6'b111111);
        end
        chk("R5 bod unchanged", bod_en, 1'b1);
    endtask

    task automatic t_unlock();
        cfg_write(1'b0, 1'b1);
        chk("R11 locked write ignored", bod_sleep, 1'b0);
        cfg_write(1'b1, 1'b1);
        chk("R11 opening write keeps bit", bod_sleep, 1'b0);
        repeat (4) @(negedge clk);
        cfg_write(1'b0, 1'b1);
        chk("R11 write after window ignored", bod_sleep, 1'b0);
        cfg_write(1'b1, 1'b1);
        repeat (3) @(negedge clk);
        cfg_write(1'b0, 1'b1);
        chk("R11 write at last window cycle", bod_sleep, 1'b1);
        cfg_write(1'b0, 1'b0);
        chk("R11 window closed after load", bod_sleep, 1'b1);
    endtask

    task automatic t_settle();
        int n;
        request_sleep(3'b000, 1'b1);
        chk("R9 light keeps bod on", bod_en, 1'b1);
        wake_bit(1);
        request_sleep(3'b001, 1'b1);
        chk("R9 quiet keeps bod on", bod_en, 1'b1);
        wake_bit(1);
        request_sleep(3'b010, 1'b1);
        chk("R9 deep drops bod", bod_en, 1'b0);
        wake_bit(2);
        chk("R10 bod back on at wake", bod_en, 1'b1);
        n = 0;
        while (!clk_en_cpu && n < SETTLE + 20) begin
            n++;
            @(negedge clk);
        end
        chk("R10 settle cycle count", n, SETTLE);
        chk("R10 after settle gates", gates(), 6'b111111);
    endtask

    task automatic t_same_cycle();
        set_bods(1'b0);
        cfg_write(1'b1, 1'b1);
        cfg_wr = 1'b1; cfg_unlock = 1'b0; cfg_bods = 1'b1;
        request_sleep(3'b010, 1'b1);
        cfg_wr = 1'b0; cfg_bods = 1'b0;
        chk("R12 bit updated", bod_sleep, 1'b1);
        chk("R12 sleep used old bit", bod_en, 1'b1);
        chk("R12 deep gates", gates(), 6'b000000);
        wake_bit(6);
        chk("R12 no settle after wake", clk_en_cpu, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_light();
        t_quiet();
        t_deep();
        t_noop();
        t_unlock();
        t_settle();
        t_same_cycle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R1-all actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule